// File: doc/BRIEF.md
# Asynchronous Byte-Wide SRAM Strobe Sequencer

This block sits between a synchronous host and an asynchronous static RAM with a 17-bit address and an 8-bit data bus. The host hands over one request at a time through a valid/ready handshake. Each request carries a direction bit, an address and, for stores, a byte. The block turns each request into the chip-enable, output-enable and write-enable sequence the RAM needs. A load returns its byte as a one-cycle response pulse.

Every timing interval is set in nanoseconds and turned into clock cycles by rounding up, with a floor of one cycle. The intervals are: address setup before the write strobe, the write-strobe width, address and data hold after the strobe ends, read access, the minimum cycle time, and bus turnaround. A store holds the address and data for the whole write and for the hold interval after it. A load samples the RAM only after the full access interval. The data bus is split into an outgoing byte, a drive enable and an incoming byte. At the chip edge these meet in one tristate pad, and the sequencer never lets both ends drive it at once.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset, chip enable, output enable and write enable are high (inactive), the data drive enable is low, response-valid is low and the block is ready.
- R2: A load holds chip enable and output enable low and write enable high, and returns the byte stored at the address on `rsp_rdata` with `rsp_valid` high. Counted from the accepting clock edge, `rsp_valid` rises ACC_CYC cycles later. ACC_CYC is the access time in cycles, 4 at the default settings. Output enable stays low for exactly ACC_CYC cycles before the capture.
- R3: A store drives write enable low for exactly WE_CYC cycles (3 at the default settings). Chip enable stays low and output enable stays high for that whole time. The byte is written to the addressed location.
- R4: During a store, the data drive enable is high and the outgoing byte is stable from the accepting edge through SETUP_CYC + WE_CYC cycles. It stays high and stable for HOLD_CYC cycles after write enable rises.
- R5: The RAM address stays constant while chip enable is low and for the cycle after write enable rises.
- R6: The data drive enable and a low output enable never occur in the same cycle.
- R7: A load accepted after a store spends TURN_CYC cycles (1 at the default settings) with chip enable low and output enable high before output enable falls. Its response therefore arrives TURN_CYC + ACC_CYC cycles after acceptance.
- R8: `req_ready` is high only when the block is idle and at least CYC_CYC cycles have passed since the last accepted request. Back-to-back accepts are spaced as follows:
  - after a store: SETUP_CYC + WE_CYC + HOLD_CYC + 1 cycles;
  - after a load: that load's response latency + 1 cycles.
- R9: `rsp_valid` is a single-cycle pulse. It occurs once per load and never for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | Load data valid (one cycle) |
| rsp_rdata | output | 8 | Load data |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_o | output | 8 | Byte driven toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Byte returned by the RAM |

## Verification
The hardest situation to reach is a load issued directly behind a store, where the turnaround interval and the access count must line up exactly. The bench issues stores and loads back to back, with the driver offering each request at the first idle cycle. The RAM model in the bench returns a garbage byte until output enable has been low for the full access interval at a stable address. A capture even one cycle early is therefore seen as wrong data. Latency and accept spacing are timed against the counts in the requirements.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD_TURN,
    PH_RD_ACC,
    PH_WR_SETUP,
    PH_WR_PULSE,
    PH_WR_HOLD
  } phase_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } strobe_t;

  // Round a time up to whole clock cycles, never less than one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Strobe levels that belong to each phase.
  function automatic strobe_t strobes_for(input phase_e p);
    strobe_t s;
    s.ce_n = 1'b1; s.oe_n = 1'b1; s.we_n = 1'b1; s.dq_oe = 1'b0;
    case (p)
      PH_RD_TURN:  s.ce_n = 1'b0;
      PH_RD_ACC:   begin s.ce_n = 1'b0; s.oe_n = 1'b0; end
      PH_WR_SETUP: begin s.ce_n = 1'b0; s.dq_oe = 1'b1; end
      PH_WR_PULSE: begin s.ce_n = 1'b0; s.we_n = 1'b0; s.dq_oe = 1'b1; end
      PH_WR_HOLD:  s.dq_oe = 1'b1;
      default:     ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_strobe_ctrl.sv
`timescale 1ns/1ps
module sram_strobe_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned AW            = 17,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_NS        = 20,
  parameter int unsigned ACCESS_NS     = 70,
  parameter int unsigned CYCLE_NS      = 70,
  parameter int unsigned WE_PULSE_NS   = 55,
  parameter int unsigned ADDR_SETUP_NS = 0,
  parameter int unsigned ADDR_HOLD_NS  = 5,
  parameter int unsigned TURN_NS       = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int unsigned ACC_CYC   = ns_to_cycles(ACCESS_NS, CLK_NS);
  localparam int unsigned CYC_CYC   = ns_to_cycles(CYCLE_NS, CLK_NS);
  localparam int unsigned WE_CYC    = ns_to_cycles(WE_PULSE_NS, CLK_NS);
  localparam int unsigned SETUP_CYC = ns_to_cycles(ADDR_SETUP_NS, CLK_NS);
  localparam int unsigned HOLD_CYC  = ns_to_cycles(ADDR_HOLD_NS, CLK_NS);
  localparam int unsigned TURN_CYC  = ns_to_cycles(TURN_NS, CLK_NS);
  localparam int unsigned MAX_CYC   = max2(max2(max2(ACC_CYC, CYC_CYC), max2(WE_CYC, SETUP_CYC)),
                                           max2(HOLD_CYC, TURN_CYC));
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);

  phase_e  state, nxt;
  strobe_t strb_q, strb_d;
  logic    last_was_write;

  // Named internal events
  logic accept, phase_done, cycle_open, capture, phase_load;

  function automatic logic [CW-1:0] phase_len_m1(input phase_e p);
    int unsigned n;
    case (p)
      PH_RD_TURN:  n = TURN_CYC;
      PH_RD_ACC:   n = ACC_CYC;
      PH_WR_SETUP: n = SETUP_CYC;
      PH_WR_PULSE: n = WE_CYC;
      PH_WR_HOLD:  n = HOLD_CYC;
      default:     n = 1;
    endcase
    return CW'(n - 1);
  endfunction

  assign req_ready  = (state == PH_IDLE) && cycle_open;
  assign accept     = req_valid && req_ready;
  assign capture    = (state == PH_RD_ACC) && phase_done;
  assign phase_load = (nxt != state) && (nxt != PH_IDLE);

  always_comb begin
    nxt = state;
    case (state)
      PH_IDLE: if (accept)
                 nxt = req_write ? PH_WR_SETUP : (last_was_write ? PH_RD_TURN : PH_RD_ACC);
      PH_RD_TURN:  if (phase_done) nxt = PH_RD_ACC;
      PH_RD_ACC:   if (phase_done) nxt = PH_IDLE;
      PH_WR_SETUP: if (phase_done) nxt = PH_WR_PULSE;
      PH_WR_PULSE: if (phase_done) nxt = PH_WR_HOLD;
      PH_WR_HOLD:  if (phase_done) nxt = PH_IDLE;
      default:     nxt = PH_IDLE;
    endcase
  end

  assign strb_d = strobes_for(nxt);

  sram_phase_timer #(.W(CW)) u_phase_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (phase_load),
    .load_val (phase_len_m1(nxt)),
    .expired  (phase_done)
  );

  sram_phase_timer #(.W(CW)) u_cycle_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (CW'(CYC_CYC - 1)),
    .expired  (cycle_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= PH_IDLE;
      strb_q         <= strobes_for(PH_IDLE);
      last_was_write <= 1'b0;
      mem_addr       <= '0;
      mem_dq_o       <= '0;
      rsp_valid      <= 1'b0;
      rsp_rdata      <= '0;
    end else begin
      state     <= nxt;
      strb_q    <= strb_d;
      rsp_valid <= capture;
      if (capture) rsp_rdata <= mem_dq_i;
      if (accept) begin
        mem_addr       <= req_addr;
        last_was_write <= req_write;
        if (req_write) mem_dq_o <= req_wdata;
      end
    end
  end

  assign mem_ce_n  = strb_q.ce_n;
  assign mem_oe_n  = strb_q.oe_n;
  assign mem_we_n  = strb_q.we_n;
  assign mem_dq_oe = strb_q.dq_oe;
endmodule

// File: rtl/sram_ctl_checker.sv
`timescale 1ns/1ps
module sram_ctl_checker #(
  parameter int unsigned AW    = 17,
  parameter int unsigned DW    = 8,
  parameter int unsigned PULSE = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [DW-1:0] mem_dq_o,
  input logic          mem_dq_oe
);
  int unsigned we_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_run <= 0;
    else if (!mem_we_n) we_run <= we_run + 1;
    else                we_run <= 0;
  end

  assert_no_bus_fight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == PULSE));

  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o) && $stable(mem_addr)));

  assert_ready_when_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

  assert_rsp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_rsp_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(!mem_oe_n));
endmodule

bind sram_strobe_ctrl sram_ctl_checker #(.AW(AW), .DW(DW), .PULSE(WE_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module tb_sram_strobe_ctrl;
  // Expected cycle counts at 20 ns per clock:
  // 70 ns access -> 4, 55 ns pulse -> 3, 0 ns setup -> 1, 5 ns hold -> 1, 20 ns turn -> 1
  localparam int ACC = 4, PUL = 3, SET = 1, HLD = 1, TRN = 1, CYC = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rsp_rdata, mem_dq_o;
  logic [7:0]  mem_dq_i = 8'hA5;
  logic [16:0] mem_addr;

  sram_strobe_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    finish_run();
  end

  // RAM model
  logic [7:0] ram [int];
  logic [7:0] shadow [int];
  int acc_cnt = 0;
  logic [16:0] prev_addr = '0;
  bit pend = 0; logic [16:0] paddr; logic [7:0] pdat;
  int we_low = 0;

  always @(negedge clk) if (rst_n) begin
    bit rd_on;
    rd_on = !mem_ce_n && !mem_oe_n && mem_we_n;
    acc_cnt = rd_on ? ((mem_addr == prev_addr && acc_cnt > 0) ? acc_cnt + 1 : 1) : 0;
    prev_addr = mem_addr;
    mem_dq_i <= (rd_on && acc_cnt >= ACC) ? (ram.exists(mem_addr) ? ram[mem_addr] : 8'h00) : 8'hA5;
    if (mem_dq_oe && !mem_oe_n) check(0, "R6 bus fight", 1, 0);
    if (!mem_we_n && !mem_ce_n) begin
      if (!pend) begin paddr = mem_addr; pdat = mem_dq_o; end
      pend = 1;
      we_low++;
    end else if (pend) begin
      check(we_low == PUL, "R3 write pulse width", we_low, PUL);
      check(mem_dq_oe && mem_dq_o == pdat, "R4 data hold", mem_dq_o, pdat);
      ram[paddr] = pdat;
      pend = 0; we_low = 0;
    end
  end

  // Scoreboard
  typedef struct { logic [16:0] a; logic [7:0] d; int lat; int t0; } item_t;
  item_t sb[$];

  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (sb.size() == 0) check(0, "R9 response without load", 1, 0);
    else begin
      item_t it;
      it = sb.pop_front();
      check(rsp_rdata == it.d, "R2 load data", rsp_rdata, it.d);
      check(cyc - it.t0 == it.lat, (it.lat == ACC) ? "R2 latency" : "R7 turnaround latency",
            cyc - it.t0, it.lat);
    end
  end

  bit prev_wr = 0, have_prev = 0;
  int last_acc = 0, gap_exp = 0;

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d, input bit b2b);
    int lat;
    while (!req_ready) @(negedge clk);
    if (b2b && have_prev)
      check(cyc + 1 - last_acc == gap_exp, "R8 accept spacing", cyc + 1 - last_acc, gap_exp);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    lat = prev_wr ? TRN + ACC : ACC;
    if (!wr) sb.push_back('{a, shadow.exists(a) ? shadow[a] : 8'h00, lat, cyc + 1});
    else shadow[a] = d;
    gap_exp = wr ? SET + PUL + HLD + 1 : lat + 1;
    if (gap_exp < CYC) gap_exp = CYC;
    @(negedge clk);
    req_valid = 0;
    last_acc = cyc; prev_wr = wr; have_prev = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    check(!mem_dq_oe, "R1 drive off", mem_dq_oe, 0);
    check(!rsp_valid, "R1 no response", rsp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check(req_ready, "R1 ready", req_ready, 1);

    issue(1, 17'h00000, 8'h3C, 0);
    issue(1, 17'h1FFFF, 8'hC3, 1);
    issue(1, 17'h0ABCD, 8'h5A, 1);
    issue(0, 17'h00000, 8'h00, 1);   // load right behind store (R7)
    issue(0, 17'h1FFFF, 8'h00, 1);   // load behind load (R2)
    issue(0, 17'h0ABCD, 8'h00, 1);
    issue(0, 17'h12345, 8'h00, 1);   // never written
    for (int i = 0; i < 16; i++) issue(1, 17'(1) << i, 8'(i * 17 + 1), 1);
    for (int i = 0; i < 16; i++) begin
      issue(0, 17'(1) << i, 8'h00, 1);
      issue(1, 17'(1) << i, 8'(8'hF0 ^ i), 1);
    end
    for (int i = 0; i < 16; i++) issue(0, 17'(1) << i, 8'h00, 1);
    repeat (10) @(negedge clk);
    issue(1, 17'h00042, 8'h77, 0);
    repeat (10) @(negedge clk);
    issue(0, 17'h00042, 8'h00, 0);   // load long after a store still turns around
    repeat (20) @(negedge clk);
    check(sb.size() == 0, "R9 all loads answered", sb.size(), 0);
    check(mem_ce_n && !mem_dq_oe && req_ready, "R8 idle at end", {mem_ce_n, mem_dq_oe, req_ready}, 3'b101);
    finish_run();
  end
endmodule